// File: doc/BRIEF.md
# Prioritized Window Overlay With Drop Shadows

This block paints rectangular background windows for an on-screen display overlay. A host loads up to four window descriptors through a simple write port. Each descriptor holds inclusive character-cell bounds for rows and columns, a fill color, an enable, a shadow enable, a shadow color and two 2-bit codes that set how far the drop shadow is offset. Every pixel clock, the display timing logic presents the current character row and column and the dot and line offsets inside that cell. One cycle later the block returns a 3-bit RGB color and a flag. The flag tells the blanking logic that a window or a shadow covers the pixel.

A shadow is the window's rectangle moved right by the shadow width and down by the shadow height, in pixels and lines. Only the part not covered by the window itself is shown. Overlaps are settled by a fixed priority: a region of a higher-priority window, whether body or shadow, hides every lower-priority window. A single clear strobe turns off all four windows at once.

Top module: `osd_window_overlay`

## Requirements
- R1: After reset every window is disabled, and both outputs read 0 for any pixel position.
- R2: A pixel whose cell row lies in [row_lo, row_hi] and whose cell column lies in [col_lo, col_hi] of an enabled window shows that window's fill color with ovl_active = 1. Both bounds are inclusive. The result appears on the outputs one clock after the position is presented.
- R3: A window whose row_lo > row_hi or col_lo > col_hi produces neither body nor shadow, even when its enable is set.
- R4: Window index 0 has the highest priority and index 3 the lowest. Where regions overlap, the lowest-indexed window that covers the pixel decides the color.
- R5: The absolute pixel column is x = cell_col*12 + dot_x. The shadow spans x from col_lo*12 + W to (col_hi+1)*12 + W - 1, where W = 2, 4, 6 or 8 for width code 0, 1, 2 or 3.
- R6: The absolute line is y = cell_row*18 + dot_y. The shadow spans y from row_lo*18 + H to (row_hi+1)*18 + H - 1, where H = 2, 4, 6 or 8 for height code 0, 1, 2 or 3.
- R7: The shadow is drawn only when the window's shadow enable is set. It is drawn in the window's shadow color with ovl_active = 1, and it never covers the window's own body.
- R8: The body of a higher-priority window hides the shadow of a lower-priority window. The shadow of a higher-priority window hides the body of a lower-priority window.
- R9: A one-cycle en_clear pulse clears the enable of all four windows from the next cycle on. When a write arrives in the same cycle, the clear still wins for the enable, and the write's other fields are stored.
- R10: A pixel covered by no window and no shadow gives ovl_rgb = 0 and ovl_active = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Write strobe for one window descriptor |
| cfg_sel | input | 2 | Index of the window being written |
| cfg_row_lo | input | 4 | First character row of the window |
| cfg_row_hi | input | 4 | Last character row of the window |
| cfg_col_lo | input | 5 | First character column of the window |
| cfg_col_hi | input | 5 | Last character column of the window |
| cfg_en | input | 1 | Window enable |
| cfg_sh_en | input | 1 | Shadow enable |
| cfg_color | input | 3 | Fill color {R,G,B} |
| cfg_sh_w | input | 2 | Shadow width code |
| cfg_sh_h | input | 2 | Shadow height code |
| cfg_sh_color | input | 3 | Shadow color {R,G,B} |
| en_clear | input | 1 | Clears the enables of all windows |
| cell_row | input | 4 | Current character row |
| cell_col | input | 5 | Current character column |
| dot_x | input | 4 | Dot offset within the cell (0..11) |
| dot_y | input | 5 | Line offset within the cell (0..17) |
| ovl_rgb | output | 3 | Registered overlay color |
| ovl_active | output | 1 | Registered window-or-shadow coverage flag |

## Verification
The hardest cases to reach are the exact edges of a shadow. There, one extra dot or line moves the pixel from the shadow color to black, and the distance depends on the width or height code. The bench uses a small 2x2-cell window and sweeps all four codes. For each code it probes the last covered dot or line and the first uncovered one. It chooses cell and offset pairs that place those positions just past the window edge, and it keeps the other axis inside the shadow band. The overlap cases are built by placing a shadowed window partly under another window and probing a pixel that lies in both regions.

// File: rtl/osd_win_pkg.sv
package osd_win_pkg;

    localparam int ROW_W   = 4;
    localparam int COL_W   = 5;
    localparam int RGB_W   = 3;
    localparam int CODE_W  = 2;

    typedef struct packed {
        logic [ROW_W-1:0]  row_lo;
        logic [ROW_W-1:0]  row_hi;
        logic [COL_W-1:0]  col_lo;
        logic [COL_W-1:0]  col_hi;
        logic              en;
        logic              sh_en;
        logic [RGB_W-1:0]  color;
        logic [CODE_W-1:0] sh_w;
        logic [CODE_W-1:0] sh_h;
        logic [RGB_W-1:0]  sh_color;
    } win_cfg_t;

    typedef struct packed {
        logic [RGB_W-1:0] rgb;
        logic             active;
    } ovl_out_t;

endpackage

// File: rtl/osd_win_regs.sv
module osd_win_regs
    import osd_win_pkg::*;
#(
    parameter int NWIN  = 4,
    parameter int SEL_W = $clog2(NWIN)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [SEL_W-1:0]      sel,
    input  win_cfg_t              wdata,
    input  logic                  clr,
    output win_cfg_t [NWIN-1:0]   cfg_o
);

    typedef struct packed {
        win_cfg_t [NWIN-1:0] w;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            regs_d.w[sel] = wdata;
        end
        if (clr) begin
            for (int i = 0; i < NWIN; i++) begin
                regs_d.w[i].en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cfg_o = regs_q.w;

    logic [NWIN-1:0] en_vec;
    always_comb begin
        for (int i = 0; i < NWIN; i++) begin
            en_vec[i] = cfg_o[i].en;
        end
    end

    // R9: clear strobe leaves every window disabled on the next cycle
    a_r9_clear_drops_enables: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (en_vec == '0));

endmodule

// File: rtl/osd_win_hit.sv
module osd_win_hit
    import osd_win_pkg::*;
#(
    parameter int CELL_W = 12,
    parameter int CELL_H = 18,
    parameter int XW     = 9,
    parameter int YW     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  win_cfg_t          cfg,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic [XW-1:0]     px_x,
    input  logic [YW-1:0]     px_y,
    output logic              in_body,
    output logic              in_shadow
);

    localparam int OFS_W = CODE_W + 2;

    logic             bounds_ok;
    logic [OFS_W-1:0] sh_dx, sh_dy;
    logic [XW-1:0]    x_lo, x_hi;
    logic [YW-1:0]    y_lo, y_hi;
    logic             body_raw, shadow_raw;

    always_comb begin
        bounds_ok = (cfg.row_lo <= cfg.row_hi) && (cfg.col_lo <= cfg.col_hi);
        sh_dx = OFS_W'({cfg.sh_w, 1'b0}) + OFS_W'(2);
        sh_dy = OFS_W'({cfg.sh_h, 1'b0}) + OFS_W'(2);
        x_lo  = XW'(cfg.col_lo) * XW'(CELL_W) + XW'(sh_dx);
        x_hi  = (XW'(cfg.col_hi) + XW'(1)) * XW'(CELL_W) + XW'(sh_dx);
        y_lo  = YW'(cfg.row_lo) * YW'(CELL_H) + YW'(sh_dy);
        y_hi  = (YW'(cfg.row_hi) + YW'(1)) * YW'(CELL_H) + YW'(sh_dy);

        body_raw   = (row >= cfg.row_lo) && (row <= cfg.row_hi) &&
                     (col >= cfg.col_lo) && (col <= cfg.col_hi);
        shadow_raw = (px_x >= x_lo) && (px_x < x_hi) &&
                     (px_y >= y_lo) && (px_y < y_hi);

        in_body   = cfg.en && bounds_ok && body_raw;
        in_shadow = cfg.en && bounds_ok && cfg.sh_en && shadow_raw && !body_raw;
    end

    // R3: reversed bounds never light a pixel
    a_r3_bad_bounds_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg.row_lo > cfg.row_hi) || (cfg.col_lo > cfg.col_hi)) |-> !(in_body || in_shadow));

    // R7: shadow needs its own enable
    a_r7_shadow_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.sh_en |-> !in_shadow);

    // R7: a window's shadow never lands on its own body
    a_r7_shadow_off_body: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_body && in_shadow));

endmodule

// File: rtl/osd_win_prio.sv
module osd_win_prio
    import osd_win_pkg::*;
#(
    parameter int NWIN = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  win_cfg_t [NWIN-1:0]  cfg,
    input  logic [NWIN-1:0]      in_body,
    input  logic [NWIN-1:0]      in_shadow,
    output logic [NWIN-1:0]      winner,
    output logic [RGB_W-1:0]     rgb,
    output logic                 active
);

    always_comb begin
        logic found;
        found  = 1'b0;
        winner = '0;
        rgb    = '0;
        for (int i = 0; i < NWIN; i++) begin
            if (!found && (in_body[i] || in_shadow[i])) begin
                found     = 1'b1;
                winner[i] = 1'b1;
                rgb       = in_body[i] ? cfg[i].color : cfg[i].sh_color;
            end
        end
        active = found;
    end

    // R4: at most one window owns a pixel
    a_r4_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(winner));

    // R4: the top-priority window always wins where it lies
    a_r4_top_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (in_body[0] || in_shadow[0]) |-> winner[0]);

endmodule

// File: rtl/osd_window_overlay.sv
module osd_window_overlay
    import osd_win_pkg::*;
#(
    parameter int NWIN   = 4,
    parameter int CELL_W = 12,
    parameter int CELL_H = 18,
    localparam int SEL_W = $clog2(NWIN),
    localparam int DX_W  = $clog2(CELL_W),
    localparam int DY_W  = $clog2(CELL_H)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [SEL_W-1:0]         cfg_sel,
    input  logic [ROW_W-1:0]         cfg_row_lo,
    input  logic [ROW_W-1:0]         cfg_row_hi,
    input  logic [COL_W-1:0]         cfg_col_lo,
    input  logic [COL_W-1:0]         cfg_col_hi,
    input  logic                     cfg_en,
    input  logic                     cfg_sh_en,
    input  logic [RGB_W-1:0]         cfg_color,
    input  logic [CODE_W-1:0]        cfg_sh_w,
    input  logic [CODE_W-1:0]        cfg_sh_h,
    input  logic [RGB_W-1:0]         cfg_sh_color,
    input  logic                     en_clear,
    input  logic [ROW_W-1:0]         cell_row,
    input  logic [COL_W-1:0]         cell_col,
    input  logic [DX_W-1:0]          dot_x,
    input  logic [DY_W-1:0]          dot_y,
    output logic [RGB_W-1:0]         ovl_rgb,
    output logic                     ovl_active
);

    localparam int MAX_SH = 8;
    localparam int XW = $clog2(((1 << COL_W) + 1) * CELL_W + MAX_SH + 1);
    localparam int YW = $clog2(((1 << ROW_W) + 1) * CELL_H + MAX_SH + 1);

    win_cfg_t            wdata;
    win_cfg_t [NWIN-1:0] cfg;
    logic [XW-1:0]       px_x;
    logic [YW-1:0]       px_y;
    logic [NWIN-1:0]     in_body, in_shadow, winner;
    logic [RGB_W-1:0]    p_rgb;
    logic                p_active;
    ovl_out_t            out_d, out_q;

    always_comb begin
        wdata.row_lo   = cfg_row_lo;
        wdata.row_hi   = cfg_row_hi;
        wdata.col_lo   = cfg_col_lo;
        wdata.col_hi   = cfg_col_hi;
        wdata.en       = cfg_en;
        wdata.sh_en    = cfg_sh_en;
        wdata.color    = cfg_color;
        wdata.sh_w     = cfg_sh_w;
        wdata.sh_h     = cfg_sh_h;
        wdata.sh_color = cfg_sh_color;
    end

    osd_win_regs #(.NWIN(NWIN), .SEL_W(SEL_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (wdata),
        .clr   (en_clear),
        .cfg_o (cfg)
    );

    always_comb begin
        px_x = XW'(cell_col) * XW'(CELL_W) + XW'(dot_x);
        px_y = YW'(cell_row) * YW'(CELL_H) + YW'(dot_y);
    end

    for (genvar g = 0; g < NWIN; g++) begin : g_hit
        osd_win_hit #(
            .CELL_W (CELL_W),
            .CELL_H (CELL_H),
            .XW     (XW),
            .YW     (YW)
        ) u_hit (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg       (cfg[g]),
            .row       (cell_row),
            .col       (cell_col),
            .px_x      (px_x),
            .px_y      (px_y),
            .in_body   (in_body[g]),
            .in_shadow (in_shadow[g])
        );
    end

    osd_win_prio #(.NWIN(NWIN)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .in_body   (in_body),
        .in_shadow (in_shadow),
        .winner    (winner),
        .rgb       (p_rgb),
        .active    (p_active)
    );

    always_comb begin
        out_d.rgb    = p_rgb;
        out_d.active = p_active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign ovl_rgb    = out_q.rgb;
    assign ovl_active = out_q.active;

    // R10: an uncovered pixel is black
    a_r10_idle_black: assert property (@(posedge clk) disable iff (!rst_n)
        !ovl_active |-> (ovl_rgb == '0));

    // R2: a winning window one cycle earlier shows up as coverage now
    a_r2_one_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (winner != '0) |=> ovl_active);

endmodule

// File: tb/test_osd_window_overlay.sv
module test_osd_window_overlay;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [3:0] cfg_row_lo = '0, cfg_row_hi = '0;
    logic [4:0] cfg_col_lo = '0, cfg_col_hi = '0;
    logic       cfg_en = 1'b0, cfg_sh_en = 1'b0;
    logic [2:0] cfg_color = '0, cfg_sh_color = '0;
    logic [1:0] cfg_sh_w = '0, cfg_sh_h = '0;
    logic       en_clear = 1'b0;
    logic [3:0] cell_row = '0;
    logic [4:0] cell_col = '0;
    logic [3:0] dot_x = '0;
    logic [4:0] dot_y = '0;
    logic [2:0] ovl_rgb;
    logic       ovl_active;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    osd_window_overlay i_osd_window_overlay (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_row_lo(cfg_row_lo), .cfg_row_hi(cfg_row_hi),
        .cfg_col_lo(cfg_col_lo), .cfg_col_hi(cfg_col_hi),
        .cfg_en(cfg_en), .cfg_sh_en(cfg_sh_en), .cfg_color(cfg_color),
        .cfg_sh_w(cfg_sh_w), .cfg_sh_h(cfg_sh_h), .cfg_sh_color(cfg_sh_color),
        .en_clear(en_clear), .cell_row(cell_row), .cell_col(cell_col),
        .dot_x(dot_x), .dot_y(dot_y), .ovl_rgb(ovl_rgb), .ovl_active(ovl_active)
    );

    task automatic wr_win(input int idx, input int rl, input int rh, input int cl, input int ch,
                          input bit en, input bit she, input int col, input int sw,
                          input int sh, input int scol, input bit clr_too);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(idx);
        cfg_row_lo = 4'(rl); cfg_row_hi = 4'(rh);
        cfg_col_lo = 5'(cl); cfg_col_hi = 5'(ch);
        cfg_en = en; cfg_sh_en = she; cfg_color = 3'(col);
        cfg_sh_w = 2'(sw); cfg_sh_h = 2'(sh); cfg_sh_color = 3'(scol);
        en_clear = clr_too;
        @(negedge clk);
        cfg_we = 1'b0; en_clear = 1'b0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        en_clear = 1'b1;
        @(negedge clk);
        en_clear = 1'b0;
    endtask

    task automatic probe(input string req, input int r, input int c, input int dx, input int dy,
                         input bit exp_act, input int exp_rgb);
        @(negedge clk);
        cell_row = 4'(r); cell_col = 5'(c); dot_x = 4'(dx); dot_y = 5'(dy);
        @(posedge clk);
        #1;
        total++;
        if (ovl_active !== exp_act || ovl_rgb !== 3'(exp_rgb)) begin
            bad++;
            $display("FAIL %s at row=%0d col=%0d dx=%0d dy=%0d: got act=%0b rgb=%0d, expected act=%0b rgb=%0d",
                     req, r, c, dx, dy, ovl_active, ovl_rgb, exp_act, exp_rgb);
        end
    endtask

    // R1 R10: reset state
    task automatic t_reset();
        total++;
        if (ovl_active !== 1'b0 || ovl_rgb !== 3'd0) begin
            bad++;
            $display("FAIL R1 reset outputs: got act=%0b rgb=%0d, expected 0 0", ovl_active, ovl_rgb);
        end
        probe("R1", 0, 0, 0, 0, 0, 0);
        probe("R1", 7, 15, 5, 9, 0, 0);
    endtask

    // R2 inclusive bounds; R10 outside is black
    task automatic t_basic();
        wr_win(0, 2, 4, 5, 9, 1, 0, 5, 0, 0, 0, 0);
        probe("R2", 2, 5, 0, 0, 1, 5);
        probe("R2", 4, 9, 11, 17, 1, 5);
        probe("R10", 1, 5, 11, 17, 0, 0);
        probe("R10", 2, 10, 0, 0, 0, 0);
        probe("R10", 5, 9, 0, 0, 0, 0);
        probe("R2", 3, 7, 6, 9, 1, 5);
    endtask

    // R3 reversed bounds
    task automatic t_bad_bounds();
        clear_all();
        wr_win(1, 6, 5, 3, 8, 1, 1, 2, 3, 3, 7, 0);
        probe("R3", 5, 4, 0, 0, 0, 0);
        probe("R3", 6, 4, 0, 0, 0, 0);
        wr_win(1, 5, 6, 8, 3, 1, 1, 2, 3, 3, 7, 0);
        probe("R3", 5, 4, 0, 0, 0, 0);
        probe("R3", 6, 8, 0, 0, 0, 0);
    endtask

    // R4 priority
    task automatic t_prio();
        clear_all();
        wr_win(2, 3, 6, 8, 12, 1, 0, 2, 0, 0, 0, 0);
        wr_win(0, 2, 4, 5, 9, 1, 0, 5, 0, 0, 0, 0);
        wr_win(3, 0, 10, 0, 20, 1, 0, 4, 0, 0, 0, 0);
        probe("R4", 3, 8, 0, 0, 1, 5);
        probe("R4", 5, 8, 0, 0, 1, 2);
        probe("R4", 3, 11, 0, 0, 1, 2);
        probe("R4", 9, 1, 0, 0, 1, 4);
    endtask

    // R5 shadow width codes; window spans x 24..47, y 36..71
    task automatic t_shadow_w();
        for (int k = 0; k < 4; k++) begin
            int w;
            w = 2 * (k + 1);
            clear_all();
            wr_win(0, 2, 3, 2, 3, 1, 1, 1, k, 0, 6, 0);
            probe("R5", 2, 4, w - 1, 5, 1, 6);
            probe("R5", 2, 4, w, 5, 0, 0);
        end
    endtask

    // R6 shadow height codes
    task automatic t_shadow_h();
        for (int k = 0; k < 4; k++) begin
            int h;
            h = 2 * (k + 1);
            clear_all();
            wr_win(0, 2, 3, 2, 3, 1, 1, 1, 0, k, 6, 0);
            probe("R6", 4, 2, 6, h - 1, 1, 6);
            probe("R6", 4, 2, 6, h, 0, 0);
        end
    endtask

    // R7 shadow enable and placement
    task automatic t_shadow_en();
        clear_all();
        wr_win(0, 2, 3, 2, 3, 1, 0, 1, 3, 3, 6, 0);
        probe("R7", 2, 4, 0, 10, 0, 0);
        probe("R7", 4, 2, 9, 0, 0, 0);
        wr_win(0, 2, 3, 2, 3, 1, 1, 1, 3, 3, 6, 0);
        probe("R7", 2, 4, 0, 10, 1, 6);
        probe("R7", 2, 4, 1, 0, 0, 0);
        probe("R7", 3, 3, 11, 17, 1, 1);
    endtask

    // R8 cover rules
    task automatic t_cover();
        clear_all();
        wr_win(1, 2, 3, 2, 3, 1, 1, 1, 3, 3, 6, 0);
        wr_win(0, 2, 5, 4, 6, 1, 0, 3, 0, 0, 0, 0);
        probe("R8", 2, 4, 3, 10, 1, 3);
        clear_all();
        wr_win(0, 2, 3, 2, 3, 1, 1, 1, 3, 3, 6, 0);
        wr_win(1, 2, 5, 4, 6, 1, 0, 3, 0, 0, 0, 0);
        probe("R8", 2, 4, 3, 10, 1, 6);
        probe("R8", 2, 5, 3, 10, 1, 3);
    endtask

    // R9 global clear
    task automatic t_clear();
        wr_win(0, 0, 1, 0, 1, 1, 0, 7, 0, 0, 0, 0);
        wr_win(3, 8, 9, 8, 9, 1, 0, 2, 0, 0, 0, 0);
        probe("R9", 0, 0, 0, 0, 1, 7);
        clear_all();
        probe("R9", 0, 0, 0, 0, 0, 0);
        probe("R9", 8, 8, 0, 0, 0, 0);
        wr_win(2, 10, 11, 10, 11, 1, 0, 5, 0, 0, 0, 1);
        probe("R9", 10, 10, 0, 0, 0, 0);
        wr_win(2, 10, 11, 10, 11, 1, 0, 5, 0, 0, 0, 0);
        probe("R9", 10, 10, 0, 0, 1, 5);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish, got timeout, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_bad_bounds();
        t_prio();
        t_shadow_w();
        t_shadow_h();
        t_shadow_en();
        t_cover();
        t_clear();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule